// File: doc/BRIEF.md
# Serial Bus Master Register Front-End

This block is the register side of a two-wire serial bus master. Software reaches it through a plain 32-bit register port with a byte offset, write enable, write data and read data. Through that port it sets a command byte, a target register address, write data, a runtime and a hardware device address, clock settings and line overrides. Setting the start bit hands one transaction to a serial engine over a pulse/done handshake. The bit-level wire timing lives in that engine, outside this block.

When the engine reports the end of a transfer, the block stores the outcome in a status register. The outcome is either completion or an error, and an error carries a missing-acknowledge flag and the index of the failing data byte. Read data is captured, masked to the access width. A single level interrupt is driven from the status bits that are enabled.

A transfer in flight can be aborted, and the whole block can be soft-reset. While the engine is busy, writes to the transaction parameters are refused, and the refusal is recorded as a load-busy condition. A separate device-mode start launches the engine's bus initialisation sequence.

Top module: `sbus_regfront`

## Requirements
- R1: After reset every register reads 0, except the device-mode register, which reads 0x007C3E00. The interrupt and all engine pulses are low.
- R2: The register offsets are 0x00 control, 0x04 clock, 0x08 interrupt enable, 0x0C status, 0x10 register address, 0x1C data, 0x24 line control, 0x28 device mode, 0x2C command and 0x30 device address. The readable fields are as follows. Clock holds divider bits 7:0 and delay bits 10:8. Interrupt enable holds bits 2:0. Register address holds bits 7:0. Data holds bits 31:0. Command holds bits 7:0. Device address holds the runtime address in bits 23:16 and the hardware address in bits 15:0. Device mode holds data code 23:16, register code 15:8 and device 7:0.
- R3: Writing control bit 7 while idle, with a valid command, gives a one-cycle eng_start in the cycle after the write. The command, address and data registers are presented on the engine outputs. Control bit 7 reads 1 until eng_done.
- R4: The valid command codes are 0x8B, 0x9C and 0xA6 (read of 8, 16 and 32 bits), 0x4E, 0x59 and 0x63 (write of 8, 16 and 32 bits) and 0xE8 (set runtime address). A start with any other code produces no eng_start, leaves control bit 7 at 0 and sets status 0x00000002.
- R5: A transfer that ends with eng_err low sets status bit 0 and clears bits 16 and 11:8. For a read command, eng_rdata is stored in the data register, masked to the access width with zero upper bits.
- R6: A transfer that ends with eng_err high sets status bit 1, bit 16 to eng_nack and bits 11:8 to eng_errbyte. The data register is left unchanged.
- R7: Writing 1 to status bits 2:0 clears them. Writing 0 to them has no effect. Writes never change bits 16 and 11:8.
- R8: irq is high exactly when control bit 1 is set and at least one of status bits 2:0 is set together with the matching enable bit.
- R9: A write to the register address, data, command or device address registers while the engine is busy is ignored and sets status bit 2.
- R10: Writing control bit 6 during a transfer gives a one-cycle eng_abort and returns to idle in the cycle after the write. No status flag is set, and a later eng_done is ignored.
- R11: Writing control bit 0 makes that bit read 1 for one cycle. At the next edge every register returns to its reset value, and an engine operation in progress receives eng_abort.
- R12: Writing device-mode bit 31 while idle gives a one-cycle eng_init. Bit 31 reads 1 until eng_done, then clears without setting any status flag.
- R13: Line-control bits 3:0 drive scl_drv_val, scl_drv_en, sda_drv_val and sda_drv_en, in that bit order from 3 down to 0. Bits 5 and 4 read scl_in and sda_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr |
| eng_start | output | 1 | Transfer launch pulse |
| eng_init | output | 1 | Device-mode sequence launch pulse |
| eng_abort | output | 1 | Abort pulse |
| eng_cmd | output | 8 | Command code |
| eng_regaddr | output | 8 | Target register address |
| eng_rta | output | 8 | Runtime address |
| eng_hwaddr | output | 16 | Hardware device address |
| eng_wdata | output | 32 | Write data |
| eng_dm_data | output | 8 | Device-mode data code |
| eng_dm_reg | output | 8 | Device-mode register code |
| eng_dm_dev | output | 8 | Device-mode device address |
| eng_done | input | 1 | Engine end of operation |
| eng_err | input | 1 | Transfer failed |
| eng_nack | input | 1 | Failure was a missing acknowledge |
| eng_errbyte | input | 4 | Failing data byte flags |
| eng_rdata | input | 32 | Read data |
| clk_div | output | 8 | Bus clock divider |
| sda_delay | output | 3 | Data output delay |
| scl_drv_en | output | 1 | Clock line override enable |
| scl_drv_val | output | 1 | Clock line override value |
| sda_drv_en | output | 1 | Data line override enable |
| sda_drv_val | output | 1 | Data line override value |
| scl_in | input | 1 | Clock line state |
| sda_in | input | 1 | Data line state |
| irq | output | 1 | Level interrupt |

## Verification
The main transfer path is driven with a seeded random mix of all seven valid commands. Engine latency, data and outcome are randomised, and about a quarter of the transfers fail with random acknowledge and byte flags. This separates the width masks, the read-versus-write capture and the two error fields from each other. Directed cases cover the remaining behaviours: an invalid code, a zero write to status, protected writes made mid-transfer, an abort followed by a late done, a soft reset during a transfer and the device-mode sequence. Each of these can only be told apart from a plain completion by the status word and the pulse outputs.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
  localparam logic [7:0] OFF_CTRL = 8'h00;
  localparam logic [7:0] OFF_CLK  = 8'h04;
  localparam logic [7:0] OFF_IEN  = 8'h08;
  localparam logic [7:0] OFF_STAT = 8'h0C;
  localparam logic [7:0] OFF_RADR = 8'h10;
  localparam logic [7:0] OFF_DATA = 8'h1C;
  localparam logic [7:0] OFF_LINE = 8'h24;
  localparam logic [7:0] OFF_DMOD = 8'h28;
  localparam logic [7:0] OFF_CMD  = 8'h2C;
  localparam logic [7:0] OFF_DADR = 8'h30;

  localparam logic [7:0] CMD_RD8  = 8'h8B;
  localparam logic [7:0] CMD_RD16 = 8'h9C;
  localparam logic [7:0] CMD_RD32 = 8'hA6;
  localparam logic [7:0] CMD_WR8  = 8'h4E;
  localparam logic [7:0] CMD_WR16 = 8'h59;
  localparam logic [7:0] CMD_WR32 = 8'h63;
  localparam logic [7:0] CMD_SRTA = 8'hE8;

  localparam int DIV_W = 8;
  localparam int DLY_W = 3;
  localparam int NFLAG = 3;

  typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_INIT} xstate_t;

  typedef struct packed {
    logic             gie;
    logic [DIV_W-1:0] div;
    logic [DLY_W-1:0] dly;
    logic [NFLAG-1:0] ien;
    logic [7:0]       radr;
    logic [31:0]      data;
    logic [3:0]       line;
    logic [7:0]       dm_data;
    logic [7:0]       dm_reg;
    logic [7:0]       dm_dev;
    logic [7:0]       cmd;
    logic [7:0]       rta;
    logic [15:0]      hwa;
  } cfg_t;

  localparam cfg_t CFG_RST = '{gie: 1'b0, div: '0, dly: '0, ien: '0,
                               radr: '0, data: '0, line: '0,
                               dm_data: 8'h7C, dm_reg: 8'h3E, dm_dev: '0,
                               cmd: '0, rta: '0, hwa: '0};
endpackage

// File: rtl/sbus_rst_sync.sv
module sbus_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/sbus_cmd_decode.sv
module sbus_cmd_decode
  import sbus_pkg::*;
(
  input  logic [7:0]  code,
  output logic        valid,
  output logic        is_read,
  output logic [31:0] keep_mask
);
  always_comb begin
    valid     = 1'b1;
    is_read   = 1'b0;
    keep_mask = '0;
    case (code)
      CMD_RD8:  begin is_read = 1'b1; keep_mask = 32'h0000_00FF; end
      CMD_RD16: begin is_read = 1'b1; keep_mask = 32'h0000_FFFF; end
      CMD_RD32: begin is_read = 1'b1; keep_mask = 32'hFFFF_FFFF; end
      CMD_WR8, CMD_WR16, CMD_WR32, CMD_SRTA: ;
      default:  valid = 1'b0;
    endcase
  end
endmodule

// File: rtl/sbus_xfer_ctrl.sv
module sbus_xfer_ctrl
  import sbus_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic soft_clr,
  input  logic go_xfer,
  input  logic go_init,
  input  logic abort_req,
  input  logic eng_done,
  output logic eng_start,
  output logic eng_init,
  output logic eng_abort,
  output logic in_xfer,
  output logic in_init,
  output logic xfer_end
);
  xstate_t state_q, state_d;
  logic    start_d, init_d, abort_d;

  always_comb begin
    state_d = state_q;
    start_d = 1'b0;
    init_d  = 1'b0;
    abort_d = 1'b0;
    if (soft_clr) begin
      state_d = ST_IDLE;
      abort_d = (state_q != ST_IDLE);
    end else if (abort_req && state_q != ST_IDLE) begin
      state_d = ST_IDLE;
      abort_d = 1'b1;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (go_xfer) begin
            state_d = ST_XFER;
            start_d = 1'b1;
          end else if (go_init) begin
            state_d = ST_INIT;
            init_d  = 1'b1;
          end
        end
        ST_XFER, ST_INIT: if (eng_done) state_d = ST_IDLE;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      eng_start <= 1'b0;
      eng_init  <= 1'b0;
      eng_abort <= 1'b0;
    end else begin
      state_q   <= state_d;
      eng_start <= start_d;
      eng_init  <= init_d;
      eng_abort <= abort_d;
    end
  end

  assign in_xfer  = (state_q == ST_XFER);
  assign in_init  = (state_q == ST_INIT);
  assign xfer_end = in_xfer && eng_done && !soft_clr && !abort_req;

  assert_start_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);
  assert_start_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> in_xfer);
  assert_abort_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    eng_abort |-> (!in_xfer && !in_init));
endmodule

// File: rtl/sbus_irq_stat.sv
module sbus_irq_stat
  import sbus_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_clr,
  input  logic             set_ok,
  input  logic             set_err,
  input  logic             err_nack,
  input  logic [3:0]       err_byte,
  input  logic             set_lb,
  input  logic             w1c_we,
  input  logic [NFLAG-1:0] w1c_bits,
  input  logic [NFLAG-1:0] ien,
  input  logic             gie,
  output logic [31:0]      status,
  output logic             irq
);
  logic [NFLAG-1:0] flags_q, flags_d, clr_bits, set_bits;
  logic             nack_q, nack_d;
  logic [3:0]       byte_q, byte_d;
  logic             upd_en;

  always_comb begin
    clr_bits = w1c_we ? w1c_bits : '0;
    set_bits = {set_lb, set_err, set_ok};
    flags_d  = (flags_q & ~clr_bits) | set_bits;
    nack_d   = nack_q;
    byte_d   = byte_q;
    if (set_err) begin
      nack_d = err_nack;
      byte_d = err_byte;
    end else if (set_ok) begin
      nack_d = 1'b0;
      byte_d = '0;
    end
    if (soft_clr) begin
      flags_d = '0;
      nack_d  = 1'b0;
      byte_d  = '0;
    end
    upd_en = soft_clr | w1c_we | set_ok | set_err | set_lb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      nack_q  <= 1'b0;
      byte_q  <= '0;
    end else if (upd_en) begin
      flags_q <= flags_d;
      nack_q  <= nack_d;
      byte_q  <= byte_d;
    end
  end

  assign status = {15'b0, nack_q, 4'b0, byte_q, 5'b0, flags_q};
  assign irq    = gie && |(flags_q & ien);

  assert_done_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (set_ok && !soft_clr) |=> status[0]);
  assert_err_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (set_err && !soft_clr) |=> (status[1] && status[16] == $past(err_nack)));
  assert_load_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (set_lb && !soft_clr) |=> status[2]);
endmodule

// File: rtl/sbus_regfront.sv
module sbus_regfront
  import sbus_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              eng_start,
  output logic              eng_init,
  output logic              eng_abort,
  output logic [7:0]        eng_cmd,
  output logic [7:0]        eng_regaddr,
  output logic [7:0]        eng_rta,
  output logic [15:0]       eng_hwaddr,
  output logic [31:0]       eng_wdata,
  output logic [7:0]        eng_dm_data,
  output logic [7:0]        eng_dm_reg,
  output logic [7:0]        eng_dm_dev,
  input  logic              eng_done,
  input  logic              eng_err,
  input  logic              eng_nack,
  input  logic [3:0]        eng_errbyte,
  input  logic [31:0]       eng_rdata,
  output logic [DIV_W-1:0]  clk_div,
  output logic [DLY_W-1:0]  sda_delay,
  output logic              scl_drv_en,
  output logic              scl_drv_val,
  output logic              sda_drv_en,
  output logic              sda_drv_val,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              irq
);
  logic        rst_ni;
  cfg_t        cfg_q, cfg_d;
  logic        cfg_en;
  logic        srst_q, srst_d;
  logic        hit_ctrl, hit_clk, hit_ien, hit_stat, hit_radr, hit_data;
  logic        hit_line, hit_dmod, hit_cmd, hit_dadr;
  logic        in_xfer, in_init, busy, idle_ok, xfer_end;
  logic        cmd_valid, cmd_read;
  logic [31:0] cmd_mask;
  logic        go_xfer, go_init, cmd_bad, abort_req, set_lb;
  logic        set_ok, set_err;
  logic [31:0] status;

  sbus_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_ni));

  always_comb begin
    hit_ctrl = bus_we && bus_addr == ADDR_W'(OFF_CTRL);
    hit_clk  = bus_we && bus_addr == ADDR_W'(OFF_CLK);
    hit_ien  = bus_we && bus_addr == ADDR_W'(OFF_IEN);
    hit_stat = bus_we && bus_addr == ADDR_W'(OFF_STAT);
    hit_radr = bus_we && bus_addr == ADDR_W'(OFF_RADR);
    hit_data = bus_we && bus_addr == ADDR_W'(OFF_DATA);
    hit_line = bus_we && bus_addr == ADDR_W'(OFF_LINE);
    hit_dmod = bus_we && bus_addr == ADDR_W'(OFF_DMOD);
    hit_cmd  = bus_we && bus_addr == ADDR_W'(OFF_CMD);
    hit_dadr = bus_we && bus_addr == ADDR_W'(OFF_DADR);
  end

  sbus_cmd_decode u_dec (
    .code(cfg_q.cmd), .valid(cmd_valid), .is_read(cmd_read), .keep_mask(cmd_mask));

  assign busy    = in_xfer | in_init;
  assign idle_ok = !busy && !srst_q;

  always_comb begin
    go_xfer   = hit_ctrl && bus_wdata[7] && idle_ok && cmd_valid;
    cmd_bad   = hit_ctrl && bus_wdata[7] && idle_ok && !cmd_valid;
    go_init   = hit_dmod && bus_wdata[31] && idle_ok;
    abort_req = hit_ctrl && bus_wdata[6] && busy && !srst_q;
    set_lb    = (hit_radr | hit_data | hit_cmd | hit_dadr) && busy && !srst_q;
    srst_d    = hit_ctrl && bus_wdata[0] && !srst_q;
  end

  sbus_xfer_ctrl u_ctl (
    .clk(clk), .rst_n(rst_ni), .soft_clr(srst_q),
    .go_xfer(go_xfer), .go_init(go_init), .abort_req(abort_req),
    .eng_done(eng_done), .eng_start(eng_start), .eng_init(eng_init),
    .eng_abort(eng_abort), .in_xfer(in_xfer), .in_init(in_init),
    .xfer_end(xfer_end));

  assign set_ok  = xfer_end && !eng_err;
  assign set_err = (xfer_end && eng_err) || cmd_bad;

  sbus_irq_stat u_stat (
    .clk(clk), .rst_n(rst_ni), .soft_clr(srst_q),
    .set_ok(set_ok), .set_err(set_err),
    .err_nack(xfer_end && eng_nack),
    .err_byte(xfer_end ? eng_errbyte : 4'h0),
    .set_lb(set_lb), .w1c_we(hit_stat && !srst_q), .w1c_bits(bus_wdata[NFLAG-1:0]),
    .ien(cfg_q.ien), .gie(cfg_q.gie), .status(status), .irq(irq));

  always_comb begin
    cfg_d = cfg_q;
    if (srst_q) begin
      cfg_d = CFG_RST;
    end else begin
      if (hit_ctrl) cfg_d.gie = bus_wdata[1];
      if (hit_clk) begin
        cfg_d.div = bus_wdata[DIV_W-1:0];
        cfg_d.dly = bus_wdata[8 +: DLY_W];
      end
      if (hit_ien)  cfg_d.ien  = bus_wdata[NFLAG-1:0];
      if (hit_line) cfg_d.line = bus_wdata[3:0];
      if (hit_radr && !busy) cfg_d.radr = bus_wdata[7:0];
      if (hit_data && !busy) cfg_d.data = bus_wdata;
      if (hit_cmd && !busy)  cfg_d.cmd  = bus_wdata[7:0];
      if (hit_dadr && !busy) begin
        cfg_d.rta = bus_wdata[23:16];
        cfg_d.hwa = bus_wdata[15:0];
      end
      if (hit_dmod && !busy) begin
        cfg_d.dm_data = bus_wdata[23:16];
        cfg_d.dm_reg  = bus_wdata[15:8];
        cfg_d.dm_dev  = bus_wdata[7:0];
      end
      if (xfer_end && !eng_err && cmd_read) cfg_d.data = eng_rdata & cmd_mask;
    end
    cfg_en = srst_q | bus_we | xfer_end;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= CFG_RST;
      srst_q <= 1'b0;
    end else begin
      srst_q <= srst_d;
      if (cfg_en) cfg_q <= cfg_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(OFF_CTRL): bus_rdata = {24'b0, in_xfer, 5'b0, cfg_q.gie, srst_q};
      ADDR_W'(OFF_CLK):  bus_rdata = {21'b0, cfg_q.dly, cfg_q.div};
      ADDR_W'(OFF_IEN):  bus_rdata = {29'b0, cfg_q.ien};
      ADDR_W'(OFF_STAT): bus_rdata = status;
      ADDR_W'(OFF_RADR): bus_rdata = {24'b0, cfg_q.radr};
      ADDR_W'(OFF_DATA): bus_rdata = cfg_q.data;
      ADDR_W'(OFF_LINE): bus_rdata = {26'b0, scl_in, sda_in, cfg_q.line};
      ADDR_W'(OFF_DMOD): bus_rdata = {in_init, 7'b0, cfg_q.dm_data, cfg_q.dm_reg, cfg_q.dm_dev};
      ADDR_W'(OFF_CMD):  bus_rdata = {24'b0, cfg_q.cmd};
      ADDR_W'(OFF_DADR): bus_rdata = {8'b0, cfg_q.rta, cfg_q.hwa};
      default:           bus_rdata = '0;
    endcase
  end

  assign eng_cmd     = cfg_q.cmd;
  assign eng_regaddr = cfg_q.radr;
  assign eng_rta     = cfg_q.rta;
  assign eng_hwaddr  = cfg_q.hwa;
  assign eng_wdata   = cfg_q.data;
  assign eng_dm_data = cfg_q.dm_data;
  assign eng_dm_reg  = cfg_q.dm_reg;
  assign eng_dm_dev  = cfg_q.dm_dev;
  assign clk_div     = cfg_q.div;
  assign sda_delay   = cfg_q.dly;
  assign scl_drv_val = cfg_q.line[3];
  assign scl_drv_en  = cfg_q.line[2];
  assign sda_drv_val = cfg_q.line[1];
  assign sda_drv_en  = cfg_q.line[0];

  assert_busy_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    (hit_data && busy && !srst_q) |=> (eng_wdata == $past(eng_wdata)));
  assert_soft_reset_R11: assert property (@(posedge clk) disable iff (!rst_ni)
    srst_q |=> (!in_xfer && !in_init && !srst_q));
endmodule

// File: tb/sbus_regfront_test.sv
module sbus_regfront_test;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        eng_start, eng_init, eng_abort;
  logic [7:0]  eng_cmd, eng_regaddr, eng_rta, eng_dm_data, eng_dm_reg, eng_dm_dev;
  logic [15:0] eng_hwaddr;
  logic [31:0] eng_wdata;
  logic        eng_done = 1'b0, eng_err = 1'b0, eng_nack = 1'b0;
  logic [3:0]  eng_errbyte = '0;
  logic [31:0] eng_rdata = '0;
  logic [7:0]  clk_div;
  logic [2:0]  sda_delay;
  logic        scl_drv_en, scl_drv_val, sda_drv_en, sda_drv_val;
  logic        scl_in = 1'b0, sda_in = 1'b0;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #(CLK_NS/2) clk = ~clk;

  sbus_regfront uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .eng_start(eng_start), .eng_init(eng_init), .eng_abort(eng_abort),
    .eng_cmd(eng_cmd), .eng_regaddr(eng_regaddr), .eng_rta(eng_rta),
    .eng_hwaddr(eng_hwaddr), .eng_wdata(eng_wdata), .eng_dm_data(eng_dm_data),
    .eng_dm_reg(eng_dm_reg), .eng_dm_dev(eng_dm_dev), .eng_done(eng_done),
    .eng_err(eng_err), .eng_nack(eng_nack), .eng_errbyte(eng_errbyte),
    .eng_rdata(eng_rdata), .clk_div(clk_div), .sda_delay(sda_delay),
    .scl_drv_en(scl_drv_en), .scl_drv_val(scl_drv_val), .sda_drv_en(sda_drv_en),
    .sda_drv_val(sda_drv_val), .scl_in(scl_in), .sda_in(sda_in), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a[5:0]; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a[5:0];
    #(CLK_NS/4);
    d = bus_rdata;
  endtask

  task automatic done_pulse(input logic e, input logic n, input logic [3:0] b,
                            input logic [31:0] r);
    @(negedge clk);
    eng_done = 1'b1; eng_err = e; eng_nack = n; eng_errbyte = b; eng_rdata = r;
    @(negedge clk);
    eng_done = 1'b0; eng_err = 1'b0; eng_nack = 1'b0; eng_errbyte = '0;
  endtask

  function automatic logic [31:0] mask_of(input logic [7:0] c);
    case (c)
      8'h8B: return 32'h0000_00FF;
      8'h9C: return 32'h0000_FFFF;
      8'hA6: return 32'hFFFF_FFFF;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] stat_of(input logic e, input logic n, input logic [3:0] b);
    if (!e) return 32'h1;
    return 32'h2 | (32'(n) << 16) | (32'(b) << 8);
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] v, data_exp;
    logic [7:0] cmds [7];
    int unused_seed;
    cmds = '{8'h8B, 8'h9C, 8'hA6, 8'h4E, 8'h59, 8'h63, 8'hE8};
    unused_seed = $urandom(32'd2024);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset values
    rd(8'h00, v); chk("R1 ctrl", v, 32'h0);
    rd(8'h28, v); chk("R1 devmode", v, 32'h007C3E00);
    rd(8'h0C, v); chk("R1 status", v, 32'h0);
    chk("R1 irq/pulses", {irq, eng_start, eng_init, eng_abort}, 4'h0);

    // R2 readback of fields
    wr(8'h04, 32'hFFFF_FFFF); rd(8'h04, v); chk("R2 clock", v, 32'h7FF);
    chk("R2 clock pins", {sda_delay, clk_div}, 11'h7FF);
    wr(8'h30, 32'hAB12_3456); rd(8'h30, v); chk("R2 devaddr", v, 32'h0012_3456);
    wr(8'h10, 32'h0000_01C5); rd(8'h10, v); chk("R2 regaddr", v, 32'hC5);
    wr(8'h08, 32'hFFFF_FFFF); rd(8'h08, v); chk("R2 ien", v, 32'h7);

    // R13 line control
    scl_in = 1'b1; sda_in = 1'b0;
    wr(8'h24, 32'h0000_003A); rd(8'h24, v); chk("R13 line read", v, 32'h0000_002A);
    chk("R13 line pins", {scl_drv_val, scl_drv_en, sda_drv_val, sda_drv_en}, 4'hA);
    wr(8'h24, 32'h0);

    // R4 invalid command
    wr(8'h2C, 32'h12); wr(8'h00, 32'h80);
    chk("R4 no start", {30'b0, eng_start, 1'b0}, 32'h0);
    rd(8'h00, v); chk("R4 ctrl idle", v, 32'h0);
    rd(8'h0C, v); chk("R4 status", v, 32'h2);
    // R7 zero write has no effect, one clears
    wr(8'h0C, 32'h0); rd(8'h0C, v); chk("R7 zero write", v, 32'h2);
    wr(8'h0C, 32'h7); rd(8'h0C, v); chk("R7 w1c", v, 32'h0);

    // R3 R5 R6 random transfers
    data_exp = 32'h0;
    for (int i = 0; i < 40; i++) begin
      logic [7:0] c; logic e, n; logic [3:0] b; logic [31:0] wd, rdv; int lat;
      c = cmds[$urandom_range(0, 6)];
      e = ($urandom_range(0, 3) == 0);
      n = e ? 1'($urandom) : 1'b0;
      b = e ? 4'($urandom) : 4'h0;
      wd = $urandom; rdv = $urandom;
      lat = $urandom_range(1, 5);
      wr(8'h10, {24'b0, 8'(i * 7)});
      wr(8'h30, {8'h0, 8'h2D, 16'h03A3});
      wr(8'h1C, wd); data_exp = wd;
      wr(8'h2C, {24'b0, c});
      wr(8'h00, 32'h80);
      chk("R3 start pulse", {31'b0, eng_start}, 32'h1);
      chk("R3 engine cmd", {eng_cmd, eng_regaddr, eng_rta}, {c, 8'(i * 7), 8'h2D});
      chk("R3 engine wdata", eng_wdata, wd);
      @(negedge clk);
      chk("R3 start one cycle", {31'b0, eng_start}, 32'h0);
      repeat (lat) @(negedge clk);
      rd(8'h00, v); chk("R3 busy bit", v & 32'h80, 32'h80);
      done_pulse(e, n, b, rdv);
      if (!e && mask_of(c) != 0) data_exp = rdv & mask_of(c);
      rd(8'h0C, v); chk(e ? "R6 status" : "R5 status", v, stat_of(e, n, b));
      rd(8'h1C, v); chk(e ? "R6 data kept" : "R5 data", v, data_exp);
      rd(8'h00, v); chk("R3 idle after done", v & 32'h80, 32'h0);
      wr(8'h0C, 32'h7);
    end

    // R7 upper fields are unaffected by writes
    wr(8'h2C, 32'h9C); wr(8'h00, 32'h80);
    done_pulse(1'b1, 1'b1, 4'h4, 32'h0);
    wr(8'h0C, 32'hFFFF_FFF8); rd(8'h0C, v); chk("R7 fields kept", v, 32'h0001_0402);
    wr(8'h0C, 32'h2); rd(8'h0C, v); chk("R7 w1c keeps fields", v, 32'h0001_0400);

    // R9 load busy, R8 irq
    wr(8'h08, 32'h4);
    wr(8'h1C, 32'h1111_2222);
    wr(8'h2C, 32'h4E); wr(8'h00, 32'h82);
    chk("R8 irq low", {31'b0, irq}, 32'h0);
    wr(8'h1C, 32'hDEAD_BEEF);
    wr(8'h2C, 32'h8B);
    chk("R9 wdata kept", eng_wdata, 32'h1111_2222);
    chk("R9 cmd kept", {24'b0, eng_cmd}, 32'h4E);
    rd(8'h0C, v); chk("R9 load busy", v & 32'h7, 32'h4);
    chk("R8 irq on lb", {31'b0, irq}, 32'h1);
    done_pulse(1'b0, 1'b0, 4'h0, 32'hFFFF_FFFF);
    rd(8'h1C, v); chk("R9 data kept", v, 32'h1111_2222);
    wr(8'h08, 32'h1);
    chk("R8 irq masked", {31'b0, irq}, 32'h1);
    wr(8'h00, 32'h0);
    chk("R8 irq gie off", {31'b0, irq}, 32'h0);
    wr(8'h0C, 32'h7);

    // R10 abort
    wr(8'h00, 32'h80);
    wr(8'h00, 32'h40);
    chk("R10 abort pulse", {31'b0, eng_abort}, 32'h1);
    rd(8'h00, v); chk("R10 idle", v, 32'h0);
    done_pulse(1'b0, 1'b0, 4'h0, 32'h5555_5555);
    rd(8'h0C, v); chk("R10 no flags", v, 32'h0);
    chk("R10 abort one cycle", {31'b0, eng_abort}, 32'h0);

    // R12 device mode
    wr(8'h28, 32'h807C_3E12);
    chk("R12 init pulse", {31'b0, eng_init}, 32'h1);
    chk("R12 fields", {eng_dm_data, eng_dm_reg, eng_dm_dev}, 24'h7C3E12);
    rd(8'h28, v); chk("R12 busy", v, 32'h807C_3E12);
    done_pulse(1'b0, 1'b0, 4'h0, 32'h0);
    rd(8'h28, v); chk("R12 cleared", v, 32'h007C_3E12);
    rd(8'h0C, v); chk("R12 no flags", v, 32'h0);

    // R11 soft reset during transfer
    wr(8'h08, 32'h7); wr(8'h04, 32'h123);
    wr(8'h00, 32'h80);
    wr(8'h00, 32'h01);
    rd(8'h00, v); chk("R11 self bit", v & 32'h1, 32'h1);
    @(negedge clk);
    chk("R11 abort", {31'b0, eng_abort}, 32'h1);
    rd(8'h00, v); chk("R11 ctrl", v, 32'h0);
    rd(8'h08, v); chk("R11 ien", v, 32'h0);
    rd(8'h04, v); chk("R11 clock", v, 32'h0);
    rd(8'h28, v); chk("R11 devmode", v, 32'h007C_3E00);
    rd(8'h1C, v); chk("R11 data", v, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule